// File: doc/BRIEF.md
# I2C SCL Clock Timing Generator

This block derives the serial clock timing of an I2C controller from the system clock. A prescaler first slows the system clock to a module clock rate, expressed as a one-cycle enable pulse every prescaler + 1 system cycles. Two programmable counters then set how many module-clock cycles the SCL line stays low and high. Each phase is stretched by a fixed offset d that depends on the prescaler value: d is 7 for a prescaler of 0, 6 for a prescaler of 1, and 5 for any larger prescaler. The intended module clock range is 7 to 12 MHz.

A run input acts as the module's reset control. While it is 0 the generator is idle, SCL is requested released (high), and the configuration inputs are captured continuously. Once run goes to 1, the generator starts with a low phase. After that, new configuration values are taken up only at the end of each full period, at the close of a high phase. Two strobes tell the bit engine where it is: one marks the first system cycle of every low phase, and one marks the middle of every high phase, where data is sampled.

Top module: `scl_timing_gen`

## Requirements
- R1: While `rst` is 1 or `run` is 0, `scl_req` is 1 and `mod_tick`, `mid_stb` and `fall_stb` are 0. The cycle after `run` is sampled 0, the block is in this idle state.
- R2: While running, `mod_tick` pulses for one system cycle once every P+1 cycles, where P is the prescaler value. With the first running cycle counted as cycle 0, the first pulse is in cycle P, and a full SCL period holds exactly A+B+2d pulses.
- R3: The phase offset d is 7 when P = 0, 6 when P = 1, and 5 when P >= 2.
- R4: The low phase comes first. `scl_req` is 0 from cycle 0 and stays 0 for (P+1)*(A+d) system cycles, where A is the low count.
- R5: The high phase follows and holds `scl_req` at 1 for (P+1)*(B+d) system cycles, where B is the high count.
- R6: `mid_stb` is 1 for exactly one system cycle per high phase. That cycle is the first cycle of module-clock step floor((B+d)/2) of the high phase, counting steps from 0.
- R7: `fall_stb` is 1 for exactly one system cycle per low phase, in the first cycle of that phase. This includes cycle 0 after release and cycle (P+1)*(A+B+2d).
- R8: Changes to `presc`, `low_cnt` or `high_cnt` while running do not affect the current period. They take effect from the low phase that follows the next period end.
- R9: A low or high count of 0 is valid. That phase then lasts exactly d module-clock cycles.
- R10: Driving `run` to 0 in the middle of a period returns the block to idle in the next cycle. A later release starts again with a low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Module release: 0 holds the generator idle and captures the configuration |
| presc | input | PSC_W | Prescaler value P; module clock = system clock / (P+1) |
| low_cnt | input | CNT_W | Low phase count A |
| high_cnt | input | CNT_W | High phase count B |
| mod_tick | output | 1 | Module-clock enable, one system cycle wide |
| scl_req | output | 1 | Requested SCL level: 1 = release high, 0 = drive low |
| mid_stb | output | 1 | Middle-of-high-phase strobe for data sampling |
| fall_stb | output | 1 | First cycle of each low phase (falling edge) |

## Verification
The bench builds the block with its default 16-bit prescaler and count widths and walks small prescaler values (0, 1, 2, 4). These cover all three offset cases and both odd and even high-phase lengths, so every phase length, midpoint and tick count can be measured to the exact system cycle within a short run. Directed tests then cover a configuration change in the middle of a period, a drop of `run` in the middle of a period, and the behaviour while held in reset.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } scl_phase_e;

    localparam int OFS_W = 3;

    // Phase stretch as a function of the prescaler setting.
    function automatic logic [OFS_W-1:0] phase_offset(input logic psc_is_zero,
                                                      input logic psc_is_one);
        if (psc_is_zero)
            return 3'd7;
        else if (psc_is_one)
            return 3'd6;
        else
            return 3'd5;
    endfunction

endpackage

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold #(
    parameter int PSC_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             load,
    input  logic [PSC_W-1:0] psc_in,
    input  logic [CNT_W-1:0] lo_in,
    input  logic [CNT_W-1:0] hi_in,
    output logic             act,
    output logic [PSC_W-1:0] psc_q,
    output logic [CNT_W-1:0] lo_q,
    output logic [CNT_W-1:0] hi_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            act   <= 1'b0;
            psc_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else begin
            act <= run;
            if (!act || load) begin
                psc_q <= psc_in;
                lo_q  <= lo_in;
                hi_q  <= hi_in;
            end
        end
    end

    // Configuration only moves when idle or at a period end (R8)
    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (act && $past(act) && !$past(load)) |-> ($stable(psc_q) && $stable(lo_q) && $stable(hi_q)));

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act,
    input  logic [PSC_W-1:0] limit,
    output logic             tick,
    output logic             at_start
);

    logic [PSC_W-1:0] pc;

    always_ff @(posedge clk) begin
        if (rst || !act)
            pc <= '0;
        else if (pc == limit)
            pc <= '0;
        else
            pc <= pc + 1'b1;
    end

    assign tick     = act && (pc == limit);
    assign at_start = act && (pc == '0);

    // Divider count never runs past the captured limit (R2)
    assert_pc_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        act |-> (pc <= limit));

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
    import scl_timing_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int LEN_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act,
    input  logic             tick,
    input  logic             at_start,
    input  logic [CNT_W-1:0] lo_cnt,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic [OFS_W-1:0] ofs,
    output logic             period_end,
    output logic             scl_lvl,
    output logic             mid_stb,
    output logic             fall_stb
);

    scl_phase_e       ph;
    logic [LEN_W-1:0] pos;
    logic [LEN_W-1:0] lo_len, hi_len, mid_pos, cur_len;
    logic             phase_end;

    assign lo_len    = LEN_W'(lo_cnt) + LEN_W'(ofs);
    assign hi_len    = LEN_W'(hi_cnt) + LEN_W'(ofs);
    assign mid_pos   = hi_len >> 1;
    assign cur_len   = (ph == PH_HIGH) ? hi_len : lo_len;
    assign phase_end = tick && (pos == cur_len - 1'b1);
    assign period_end = phase_end && (ph == PH_HIGH);

    always_ff @(posedge clk) begin
        if (rst || !act) begin
            ph  <= PH_LOW;
            pos <= '0;
        end else if (phase_end) begin
            ph  <= (ph == PH_HIGH) ? PH_LOW : PH_HIGH;
            pos <= '0;
        end else if (tick) begin
            pos <= pos + 1'b1;
        end
    end

    assign scl_lvl  = !act || (ph == PH_HIGH);
    assign fall_stb = at_start && (ph == PH_LOW) && (pos == '0);
    assign mid_stb  = at_start && (ph == PH_HIGH) && (pos == mid_pos);

    // Step index stays inside the current phase length (R4, R5)
    assert_pos_bound_R4: assert property (@(posedge clk) disable iff (rst)
        act |-> (pos < cur_len));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int PSC_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PSC_W-1:0] presc,
    input  logic [CNT_W-1:0] low_cnt,
    input  logic [CNT_W-1:0] high_cnt,
    output logic             mod_tick,
    output logic             scl_req,
    output logic             mid_stb,
    output logic             fall_stb
);

    logic             act, at_start, period_end;
    logic [PSC_W-1:0] psc_q;
    logic [CNT_W-1:0] lo_q, hi_q;
    logic [OFS_W-1:0] ofs;

    scl_cfg_hold #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst(rst), .run(run), .load(period_end),
        .psc_in(presc), .lo_in(low_cnt), .hi_in(high_cnt),
        .act(act), .psc_q(psc_q), .lo_q(lo_q), .hi_q(hi_q)
    );

    assign ofs = phase_offset(psc_q == '0, psc_q == PSC_W'(1));

    scl_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst(rst), .act(act), .limit(psc_q),
        .tick(mod_tick), .at_start(at_start)
    );

    scl_phase_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .act(act), .tick(mod_tick), .at_start(at_start),
        .lo_cnt(lo_q), .hi_cnt(hi_q), .ofs(ofs),
        .period_end(period_end), .scl_lvl(scl_req),
        .mid_stb(mid_stb), .fall_stb(fall_stb)
    );

    // Idle one cycle after run is seen low (R1, R10)
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
        !run |=> (scl_req && !mod_tick && !mid_stb && !fall_stb));
    // Falling strobe only while SCL is driven low (R7)
    assert_fall_low_R7: assert property (@(posedge clk) disable iff (rst)
        fall_stb |-> !scl_req);
    // Sampling strobe only while SCL is high (R6)
    assert_mid_high_R6: assert property (@(posedge clk) disable iff (rst)
        mid_stb |-> scl_req);
    // Offset stays within its three legal values (R3)
    assert_ofs_legal_R3: assert property (@(posedge clk) disable iff (rst)
        (ofs >= 3'd5) && (ofs <= 3'd7));

endmodule

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic [15:0] presc = '0, low_cnt = '0, high_cnt = '0;
    logic        mod_tick, scl_req, mid_stb, fall_stb;

    int n_run = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    scl_timing_gen i_scl_timing_gen (
        .clk(clk), .rst(rst), .run(run), .presc(presc),
        .low_cnt(low_cnt), .high_cnt(high_cnt),
        .mod_tick(mod_tick), .scl_req(scl_req),
        .mid_stb(mid_stb), .fall_stb(fall_stb)
    );

    localparam int NV = 5;
    localparam int VEC [NV][3] = '{'{0, 0, 0}, '{1, 3, 4}, '{2, 0, 1},
                                   '{4, 10, 2}, '{0, 5, 9}};

    function automatic int exp_d(input int p);
        return (p == 0) ? 7 : (p == 1) ? 6 : 5;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
        end
    endtask

    task automatic go_idle_cfg(input int p, input int a, input int b);
        @(negedge clk);
        run = 1'b0; presc = 16'(p); low_cnt = 16'(a); high_cnt = 16'(b);
        @(negedge clk);
    endtask

    // Release and measure one period plus a margin.
    task automatic measure(input int p, input int a, input int b);
        int d, per, rise_k, mid_k, fall2_k, ticks, first_tick, mids, prev;
        d = exp_d(p);
        per = (p + 1) * (a + b + 2 * d);
        rise_k = -1; mid_k = -1; fall2_k = -1; ticks = 0; first_tick = -1; mids = 0; prev = 0;
        go_idle_cfg(p, a, b);
        run = 1'b1;
        for (int k = 0; k < per + 4; k++) begin
            @(negedge clk);
            if (k == 0) begin
                chk(scl_req == 1'b0, "R4 low first", int'(scl_req), 0);
                chk(fall_stb == 1'b1, "R7 fall at release", int'(fall_stb), 1);
            end
            if (scl_req && prev == 0 && rise_k < 0) rise_k = k;
            if (mid_stb && k < per) begin mids++; if (mid_k < 0) mid_k = k; end
            if (fall_stb && k > 0 && fall2_k < 0) fall2_k = k;
            if (mod_tick && k < per) begin ticks++; if (first_tick < 0) first_tick = k; end
            prev = int'(scl_req);
        end
        chk(rise_k == (p + 1) * (a + d), "R4 R3 R9 low length", rise_k, (p + 1) * (a + d));
        chk(fall2_k == per, "R5 R7 period end fall", fall2_k, per);
        chk(mid_k == (p + 1) * (a + d + (b + d) / 2), "R6 mid position", mid_k,
            (p + 1) * (a + d + (b + d) / 2));
        chk(mids == 1, "R6 one mid per period", mids, 1);
        chk(ticks == a + b + 2 * d, "R2 ticks per period", ticks, a + b + 2 * d);
        chk(first_tick == p, "R2 first tick", first_tick, p);
    endtask

    initial begin
        // R1: reset holds idle even with run asserted
        run = 1'b1;
        repeat (3) @(negedge clk);
        chk(scl_req && !mod_tick && !mid_stb && !fall_stb, "R1 reset idle", int'(scl_req), 1);
        @(negedge clk);
        rst = 1'b0; run = 1'b0;
        repeat (4) @(negedge clk);
        chk(scl_req && !mod_tick && !fall_stb, "R1 run low idle", int'(scl_req), 1);

        for (int v = 0; v < NV; v++)
            measure(VEC[v][0], VEC[v][1], VEC[v][2]);

        // R8: change config during low phase; takes effect next period
        begin
            int rise1, fall2, rise2, prev;
            rise1 = -1; fall2 = -1; rise2 = -1; prev = 0;
            go_idle_cfg(0, 2, 2);
            run = 1'b1;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (k == 3) begin low_cnt = 16'd10; high_cnt = 16'd10; end
                if (scl_req && prev == 0) begin
                    if (rise1 < 0) rise1 = k; else if (rise2 < 0) rise2 = k;
                end
                if (fall_stb && k > 0 && fall2 < 0) fall2 = k;
                prev = int'(scl_req);
            end
            chk(rise1 == 9, "R8 old low kept", rise1, 9);
            chk(fall2 == 18, "R8 old high kept", fall2, 18);
            chk(rise2 == 35, "R8 new low applied", rise2, 35);
        end

        // R10: drop run mid-period, then release again
        go_idle_cfg(0, 0, 0);
        run = 1'b1;
        repeat (10) @(negedge clk);
        chk(scl_req == 1'b1, "R10 in high phase", int'(scl_req), 1);
        repeat (5) @(negedge clk);
        chk(scl_req == 1'b0, "R10 in second low phase", int'(scl_req), 0);
        run = 1'b0;
        @(negedge clk);
        chk(scl_req && !mod_tick && !fall_stb && !mid_stb, "R10 idle next cycle", int'(scl_req), 1);
        repeat (8) @(negedge clk);
        chk(scl_req == 1'b1, "R10 stays idle", int'(scl_req), 1);
        measure(0, 1, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule